// File: doc/BRIEF.md
# Sub-Audible Tone Frequency Meter

This block measures the frequency of a low-frequency signalling tone that reaches it as a one-bit, hard-limited waveform. Time is cut into back-to-back measurement windows of a fixed number of reference clock ticks. The default of 122000 ticks gives 122 ms at a 1 MHz reference. Inside each window the block counts whole tone cycles between rising edges. It also counts the reference ticks that elapse after the last counted edge, so the host can work out the fraction of a cycle left over at the window boundary.

At the last tick of every window the cycle count and the leftover tick count are captured together as one result, and an interrupt is raised. The host reads the two result bytes through a one-bit-addressed read port. Reading the second byte acknowledges the interrupt.

While a window runs, the block compares each new cycle period with the previous one. If two periods differ by more than a programmable tolerance, the window is marked as noise. A window comparator then asserts a decode flag when the captured count lies between a programmed lower and upper bound and the window stayed coherent throughout. The host sets those bounds from one entry of its tone table.

Top module: `tone_freq_meter`

## Requirements
- R1: The tone input passes through two synchronizing flops, and only its rising edges are used. The first rising edge in a window arms the meter without counting. Each later rising edge in the same window adds one to the cycle count.
- R2: Windows are WIN_TICKS clocks long and follow each other with no gap. On the last clock of a window, the cycle count and the leftover tick count are captured as one pair, and all counting restarts from zero. A rising edge that falls on that last clock is dropped.
- R3: The interrupt is high from the clock after a window ends until a read with rd_sel=1. If a window ends on the same clock as that read, the interrupt stays high.
- R4: A read with rd_en=1 returns the captured cycle count (rd_sel=0) or the captured leftover tick count (rd_sel=1) on rd_data one clock later. The captured pair stays unchanged until the next window end.
- R5: The cycle count saturates at 255.
- R6: The leftover tick count is the number of clocks since the last edge that armed or counted, or since the window start if there was no such edge. It saturates at 255.
- R7: On each counted edge after the second one, the current period is compared with the previous one. A difference greater than period_tol marks the window incoherent until the window ends.
- R8: decode_ok is updated one clock after each window end. It is 1 only when min_count <= count <= max_count and the window was coherent.
- R9: After reset, rd_data, irq and decode_ok are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tone_in | input | 1 | Limited tone input, asynchronous |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | 0 selects the cycle count, 1 selects the leftover ticks |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Result-ready interrupt |
| min_count | input | 8 | Lower bound of the accepted count |
| max_count | input | 8 | Upper bound of the accepted count |
| period_tol | input | PER_W | Allowed period difference in ticks |
| decode_ok | output | 1 | Tone within bounds and coherent |

## Verification
Two events can land on the same clock: the end of a window, which sets the interrupt, and the host read of the second byte, which clears it. The bench tracks the window phase with its own model and issues the second-byte read exactly on the last clock of a window. It then checks that the interrupt is still high and that a later read returns the newly captured pair. Constrained random tones, with jittered, noisy, very fast, very slow and absent edges, are checked against the model after every window.

// File: rtl/tfm_pkg.sv
package tfm_pkg;
  typedef logic [7:0] byte_t;

  function automatic byte_t sat_inc8(input byte_t v);
    return (v == 8'hFF) ? v : v + 8'd1;
  endfunction
endpackage

// File: rtl/tfm_edge_sync.sv
module tfm_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[1:0], din};
  end

  assign rise = sh[1] & ~sh[2];

  p_rise_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/tfm_cycle_meter.sv
module tfm_cycle_meter
  import tfm_pkg::*;
#(
  parameter int WIN_TICKS = 122000,
  parameter int PER_W     = 16,
  localparam int WIN_W    = $clog2(WIN_TICKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic [PER_W-1:0] tol,
  output logic             win_end,
  output byte_t            cycles,
  output byte_t            resid,
  output logic             coh
);
  logic [WIN_W-1:0] win_cnt;
  logic             armed;
  logic             have_per;
  logic [PER_W-1:0] per, last_per, diff;

  assign win_end = (win_cnt == WIN_W'(WIN_TICKS - 1));
  assign diff    = (per >= last_per) ? per - last_per : last_per - per;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt  <= '0;
      armed    <= 1'b0;
      have_per <= 1'b0;
      per      <= '0;
      last_per <= '0;
      cycles   <= '0;
      resid    <= '0;
      coh      <= 1'b1;
    end else begin
      win_cnt <= win_end ? '0 : win_cnt + 1'b1;
      if (win_end) begin
        armed    <= 1'b0;
        have_per <= 1'b0;
        per      <= '0;
        cycles   <= '0;
        resid    <= '0;
        coh      <= 1'b1;
      end else if (rise) begin
        resid <= '0;
        per   <= '0;
        if (!armed) begin
          armed <= 1'b1;
        end else begin
          cycles   <= sat_inc8(cycles);
          last_per <= per;
          have_per <= 1'b1;
          if (have_per && (diff > tol)) coh <= 1'b0;
        end
      end else begin
        resid <= sat_inc8(resid);
        if (per != '1) per <= per + 1'b1;
      end
    end
  end

  p_cnt_sat_r5: assert property (@(posedge clk) disable iff (rst)
    (cycles == 8'hFF && !win_end) |=> cycles == 8'hFF);
  p_incoh_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (!coh && !win_end) |=> !coh);
  p_restart_r2: assert property (@(posedge clk) disable iff (rst)
    win_end |=> (cycles == 8'h00 && resid == 8'h00 && coh));
endmodule

// File: rtl/tfm_result_regs.sv
module tfm_result_regs
  import tfm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  win_end,
  input  byte_t cycles,
  input  byte_t resid,
  input  logic  coh,
  input  byte_t min_count,
  input  byte_t max_count,
  input  logic  rd_en,
  input  logic  rd_sel,
  output byte_t rd_data,
  output logic  irq,
  output logic  decode_ok
);
  byte_t cnt_q, res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      res_q     <= '0;
      decode_ok <= 1'b0;
      irq       <= 1'b0;
      rd_data   <= '0;
    end else begin
      if (win_end) begin
        cnt_q     <= cycles;
        res_q     <= resid;
        decode_ok <= coh && (cycles >= min_count) && (cycles <= max_count);
      end
      if (win_end)              irq <= 1'b1;
      else if (rd_en && rd_sel) irq <= 1'b0;
      if (rd_en) rd_data <= rd_sel ? res_q : cnt_q;
    end
  end

  p_irq_set_r3: assert property (@(posedge clk) disable iff (rst)
    win_end |=> irq);
  p_irq_clr_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel && !win_end) |=> !irq);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> ($stable(cnt_q) && $stable(res_q)));
  p_no_ok_incoh_r8: assert property (@(posedge clk) disable iff (rst)
    (win_end && !coh) |=> !decode_ok);
endmodule

// File: rtl/tone_freq_meter.sv
module tone_freq_meter
  import tfm_pkg::*;
#(
  parameter int WIN_TICKS = 122000,
  parameter int PER_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tone_in,
  input  logic             rd_en,
  input  logic             rd_sel,
  output logic [7:0]       rd_data,
  output logic             irq,
  input  logic [7:0]       min_count,
  input  logic [7:0]       max_count,
  input  logic [PER_W-1:0] period_tol,
  output logic             decode_ok
);
  logic  rise, win_end, coh;
  byte_t cycles, resid;

  tfm_edge_sync u_sync (.clk(clk), .rst(rst), .din(tone_in), .rise(rise));

  tfm_cycle_meter #(.WIN_TICKS(WIN_TICKS), .PER_W(PER_W)) u_meter (
    .clk(clk), .rst(rst), .rise(rise), .tol(period_tol),
    .win_end(win_end), .cycles(cycles), .resid(resid), .coh(coh));

  tfm_result_regs u_res (
    .clk(clk), .rst(rst), .win_end(win_end), .cycles(cycles), .resid(resid),
    .coh(coh), .min_count(min_count), .max_count(max_count),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq),
    .decode_ok(decode_ok));
endmodule

// File: tb/test_tone_freq_meter.sv
module test_tone_freq_meter;
  localparam int WIN   = 3000;
  localparam int PER_W = 16;

  logic clk = 1'b0, rst = 1'b1, tone = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
  logic [7:0] min_c = 8'd0, max_c = 8'd255;
  logic [PER_W-1:0] tol = '0;
  logic [7:0] rd_data;
  logic irq, dec_ok;
  int n_chk = 0, n_bad = 0, cyc = 0;
  int half = 50, jit = 0, mode = 1;

  always #2 clk = ~clk;

  tone_freq_meter #(.WIN_TICKS(WIN), .PER_W(PER_W)) i_tone_freq_meter (
    .clk(clk), .rst(rst), .tone_in(tone), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq(irq), .min_count(min_c), .max_count(max_c),
    .period_tol(tol), .decode_ok(dec_ok));

  function automatic logic [7:0] sat8(input logic [7:0] v);
    return (v == 8'hFF) ? v : v + 8'd1;
  endfunction
  function automatic logic band(input logic [7:0] c, input logic [7:0] lo,
                                input logic [7:0] hi, input logic ch);
    return ch && c >= lo && c <= hi;
  endfunction

  // reference model built from the requirements
  logic [2:0] m_sh;
  int m_win, m_per, m_last;
  logic m_arm, m_hp, m_coh, m_rise;
  logic [7:0] m_cyc, m_res, m_cnt_q, m_res_q;
  logic m_ok;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_sh <= 0; m_win <= 0; m_per <= 0; m_last <= 0; m_arm <= 0; m_hp <= 0;
      m_coh <= 1; m_cyc <= 0; m_res <= 0; m_cnt_q <= 0; m_res_q <= 0; m_ok <= 0;
    end else begin
      m_rise = m_sh[1] & ~m_sh[2];
      m_sh <= {m_sh[1:0], tone};
      if (m_win == WIN - 1) begin
        m_cnt_q <= m_cyc; m_res_q <= m_res;
        m_ok <= band(m_cyc, min_c, max_c, m_coh);
        m_win <= 0; m_arm <= 0; m_hp <= 0; m_per <= 0;
        m_cyc <= 0; m_res <= 0; m_coh <= 1;
      end else begin
        m_win <= m_win + 1;
        if (m_rise) begin
          m_res <= 0; m_per <= 0;
          if (!m_arm) m_arm <= 1;
          else begin
            m_cyc <= sat8(m_cyc); m_last <= m_per; m_hp <= 1;
            if (m_hp && ((m_per > m_last) ? m_per - m_last : m_last - m_per) > int'(tol))
              m_coh <= 0;
          end
        end else begin
          m_res <= sat8(m_res);
          if (m_per < 65535) m_per <= m_per + 1;
        end
      end
    end
  end

  // tone generator: mode 0 constant, 1 square with jitter, 2 random noise
  initial begin
    forever begin
      int h;
      if (mode == 2) h = 2 + int'($urandom % 60);
      else h = half + ((jit > 0) ? int'($urandom % (jit + 1)) : 0);
      repeat (h) @(negedge clk);
      if (mode != 0) tone = ~tone;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    @(negedge clk); rd_en = 1; rd_sel = sel;
    @(negedge clk); rd_en = 0; v = rd_data;
  endtask

  task automatic wait_irq();
    int t = 0;
    @(negedge clk);
    while (!irq && t < 10000) begin @(negedge clk); t++; end
    if (!irq) chk("R3 irq timeout", 0, 1);
  endtask

  // one window: returns the captured count
  task automatic window(input string tag, output logic [7:0] c, output logic [7:0] r);
    wait_irq();
    chk({"R8 decode ", tag}, dec_ok, m_ok);
    rd(0, c); chk({"R1 R4 count ", tag}, c, m_cnt_q);
    rd(1, r); chk({"R6 R4 resid ", tag}, r, m_res_q);
    chk({"R3 irq cleared ", tag}, irq, 0);
  endtask

  initial begin
    logic [7:0] c, r;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    chk("R9 rd_data", rd_data, 0); chk("R9 irq", irq, 0); chk("R9 decode", dec_ok, 0);
    rst = 0;
    // steady tone, period 100 -> ~29 cycles, accepted
    half = 50; jit = 0; tol = 2; min_c = 25; max_c = 35;
    window("steady0", c, r); window("steady", c, r);
    chk("R8 steady accepted", dec_ok, 1);
    // small jitter within tolerance
    jit = 1; tol = 4;
    window("jit0", c, r); window("jit", c, r);
    // noise: incoherent
    mode = 2; tol = 1;
    window("noise0", c, r); window("noise", c, r);
    chk("R7 noise rejected", dec_ok, 0);
    // count below lower bound
    mode = 1; jit = 0; tol = 2; min_c = 40; max_c = 50;
    window("low0", c, r); window("low", c, r);
    chk("R8 below min rejected", dec_ok, 0);
    // fast tone saturates
    half = 3; min_c = 0; max_c = 255;
    window("fast0", c, r); window("fast", c, r);
    chk("R5 count saturated", c, 255);
    // slow tone: leftover may exceed 255
    half = 600;
    window("slow0", c, r); window("slow", c, r);
    // no edges at all
    mode = 0;
    window("flat0", c, r); window("flat", c, r);
    chk("R2 no edge count", c, 0); chk("R6 no edge resid", r, 255);
    // same-cycle window end and clearing read
    mode = 1; half = 40;
    window("pre", c, r);
    @(negedge clk);
    while (m_win != WIN - 1) @(negedge clk);
    rd_en = 1; rd_sel = 1;
    @(negedge clk); rd_en = 0;
    chk("R3 set wins over clear", irq, 1);
    rd(1, r); chk("R3 R4 new resid after collision", r, m_res_q);
    rd(0, c); chk("R2 new count after collision", c, m_cnt_q);
    // constrained random windows
    for (int i = 0; i < 10; i++) begin
      mode = ($urandom % 5 == 0) ? 2 : 1;
      half = 3 + int'($urandom % 200); jit = int'($urandom % 4);
      tol = PER_W'($urandom % 8);
      min_c = 8'($urandom % 40); max_c = min_c + 8'($urandom % 60);
      window("rand", c, r);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=<190000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule